// File: doc/BRIEF.md
# DMA Read-Back Sequencer

This block supplies the byte returned each time software reads the single data port of a DMA controller. It keeps a short ordered list of readable sources, picked by a 7-bit read mask. The sources are a live status byte, the two bytes of the transfer byte counter, and the two bytes of each of the two port address counters. Reads walk the list and start again at its head after the last entry, so software can fetch a chosen subset of registers in a fixed rotation.

The list is rebuilt on request. A plain rebuild uses the mask presented on the mask input. A status-only rebuild ignores that input and selects the status byte alone. The status byte is put together from the controller's flags at the moment of the read. Its match and end-of-block bits are active low. When the list is empty, every read returns the status byte. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

Top module: `dma_readback_seq`

## Requirements
- R1: List order follows mask bit order. Mask bit 0 selects status, bit 1 the byte counter low byte, bit 2 its high byte, bit 3 the port A counter low byte, bit 4 its high byte, bit 5 the port B counter low byte and bit 6 its high byte.
- R2: A rebuild (`rebuild_i`) sets the list length to the number of set mask bits and the read pointer to 0. `mask_i` has no effect in any cycle without a rebuild.
- R3: A status-only rebuild (`stat_rebuild_i`) builds the list as if the mask were 0x01, whatever `mask_i` holds. It wins over `rebuild_i` in the same cycle.
- R4: On a read, a pointer that has reached the list length first wraps to 0. The entry at the pointer is returned and the pointer then advances by one.
- R5: With an empty list, a read returns the status byte and the pointer stays at 0.
- R6: Status byte bit 0 = `enable_i`. Bit 1 = (`mode_i` != 1) AND (`ready_n_i` != `ready_pol_i`). Bit 4 = NOT `match_seen_i`. Bit 5 = NOT `block_end_i`. Bits 2, 3, 6 and 7 are 0.
- R7: After reset `rd_data_o` is 0x38 and the list is empty.
- R8: A rebuild in the same cycle as a read takes effect first, so that read returns the first entry of the new list.
- R9: `rd_data_o` takes the selected byte at the clock edge that samples `rd_i`. It holds its value in cycles without a read, even when the sources change.
- R10: Status bytes are composed from the flag inputs present in the read cycle, never from a copy taken at rebuild time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mask_i | input | 7 | Read mask used by a rebuild |
| rebuild_i | input | 1 | Rebuild the list from `mask_i` |
| stat_rebuild_i | input | 1 | Rebuild the list with the status entry only |
| rd_i | input | 1 | Read strobe; advances the pointer |
| byte_cnt_i | input | 16 | Transfer byte counter |
| cnt_a_i | input | 16 | Port A address counter |
| cnt_b_i | input | 16 | Port B address counter |
| enable_i | input | 1 | Controller enable flag |
| mode_i | input | 2 | Transfer mode |
| ready_pol_i | input | 1 | Active ready level from the control register |
| ready_n_i | input | 1 | Current ready level (1 = not ready) |
| match_seen_i | input | 1 | A match has occurred |
| block_end_i | input | 1 | End of block reached |
| rd_data_o | output | 8 | Registered read data |

## Verification
A full mask read past its end shows the complete order and the wrap. A sparse mask followed by mask changes without a rebuild separates the latched list from the live mask input. An empty list and a status-only rebuild under a conflicting mask show the status fallback and the forced mask. Flags toggled between status reads, ready and mode combinations, a rebuild that lands on a read, and a long random phase compared against a queue model every cycle cover the live status, the priority rule and the hold behaviour.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
    localparam int NUM_SRC = 7;
    localparam int PTR_W   = $clog2(NUM_SRC + 1);
    localparam int DATA_W  = 8;
    localparam logic [DATA_W-1:0] RESET_DATA = 8'h38;

    typedef enum logic [2:0] {
        SRC_STAT  = 3'd0,
        SRC_BC_LO = 3'd1,
        SRC_BC_HI = 3'd2,
        SRC_A_LO  = 3'd3,
        SRC_A_HI  = 3'd4,
        SRC_B_LO  = 3'd5,
        SRC_B_HI  = 3'd6
    } src_e;

    typedef struct packed {
        src_e [NUM_SRC-1:0] list;
        logic [PTR_W-1:0]   len;
        logic [PTR_W-1:0]   ptr;
        logic [DATA_W-1:0]  data;
    } rb_state_t;
endpackage

// File: rtl/dma_rb_list_build.sv
module dma_rb_list_build
    import dma_rb_pkg::*;
(
    input  logic [NUM_SRC-1:0]  mask_i,
    output src_e [NUM_SRC-1:0]  list_o,
    output logic [PTR_W-1:0]    len_o
);
    logic [PTR_W-1:0] pos;

    always_comb begin
        list_o = '{default: SRC_STAT};
        pos    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (mask_i[i]) begin
                list_o[pos[2:0]] = src_e'(3'(i));
                pos = pos + 1'b1;
            end
        end
        len_o = pos;
    end
endmodule

// File: rtl/dma_rb_status.sv
module dma_rb_status
    import dma_rb_pkg::*;
(
    input  logic              enable_i,
    input  logic [1:0]        mode_i,
    input  logic              ready_pol_i,
    input  logic              ready_n_i,
    input  logic              match_seen_i,
    input  logic              block_end_i,
    output logic [DATA_W-1:0] status_o
);
    always_comb begin
        status_o    = '0;
        status_o[0] = enable_i;
        status_o[1] = (mode_i != 2'd1) && (ready_n_i != ready_pol_i);
        status_o[4] = ~match_seen_i;
        status_o[5] = ~block_end_i;
    end
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq
    import dma_rb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [6:0]        mask_i,
    input  logic              rebuild_i,
    input  logic              stat_rebuild_i,
    input  logic              rd_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic [CNT_W-1:0]  cnt_a_i,
    input  logic [CNT_W-1:0]  cnt_b_i,
    input  logic              enable_i,
    input  logic [1:0]        mode_i,
    input  logic              ready_pol_i,
    input  logic              ready_n_i,
    input  logic              match_seen_i,
    input  logic              block_end_i,
    output logic [7:0]        rd_data_o
);
    localparam logic [NUM_SRC-1:0] STAT_ONLY = NUM_SRC'(1);

    rb_state_t          st_q, st_d;
    logic [NUM_SRC-1:0] eff_mask;
    src_e [NUM_SRC-1:0] built_list;
    logic [PTR_W-1:0]   built_len;
    logic [DATA_W-1:0]  status;
    logic               any_rebuild;

    assign eff_mask    = stat_rebuild_i ? STAT_ONLY : mask_i;
    assign any_rebuild = rebuild_i | stat_rebuild_i;

    dma_rb_list_build u_build (
        .mask_i (eff_mask),
        .list_o (built_list),
        .len_o  (built_len)
    );

    dma_rb_status u_status (
        .enable_i     (enable_i),
        .mode_i       (mode_i),
        .ready_pol_i  (ready_pol_i),
        .ready_n_i    (ready_n_i),
        .match_seen_i (match_seen_i),
        .block_end_i  (block_end_i),
        .status_o     (status)
    );

    function automatic logic [DATA_W-1:0] pick(src_e s, logic [DATA_W-1:0] stat,
                                               logic [CNT_W-1:0] bc,
                                               logic [CNT_W-1:0] ca,
                                               logic [CNT_W-1:0] cb);
        case (s)
            SRC_STAT:  pick = stat;
            SRC_BC_LO: pick = bc[7:0];
            SRC_BC_HI: pick = bc[15:8];
            SRC_A_LO:  pick = ca[7:0];
            SRC_A_HI:  pick = ca[15:8];
            SRC_B_LO:  pick = cb[7:0];
            SRC_B_HI:  pick = cb[15:8];
            default:   pick = stat;
        endcase
    endfunction

    always_comb begin
        src_e [NUM_SRC-1:0] cur_list;
        logic [PTR_W-1:0]   cur_len;
        logic [PTR_W-1:0]   cur_ptr;
        st_d     = st_q;
        cur_list = st_q.list;
        cur_len  = st_q.len;
        cur_ptr  = st_q.ptr;
        if (any_rebuild) begin
            cur_list = built_list;
            cur_len  = built_len;
            cur_ptr  = '0;
            st_d.list = built_list;
            st_d.len  = built_len;
            st_d.ptr  = '0;
        end
        if (rd_i) begin
            if (cur_len == '0) begin
                st_d.data = status;
            end else begin
                if (cur_ptr >= cur_len) cur_ptr = '0;
                st_d.data = pick(cur_list[cur_ptr[2:0]], status,
                                 byte_cnt_i, cnt_a_i, cnt_b_i);
                st_d.ptr  = cur_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.list <= '{default: SRC_STAT};
            st_q.len  <= '0;
            st_q.ptr  <= '0;
            st_q.data <= RESET_DATA;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

    // R2: length equals the number of selected sources after a rebuild
    a_r2_len_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rebuild_i && !stat_rebuild_i) |=> st_q.len == PTR_W'($countones($past(mask_i))));

    // R3: status-only rebuild leaves exactly one status entry
    a_r3_stat_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_rebuild_i |=> (st_q.len == PTR_W'(1) && st_q.list[0] == SRC_STAT));

    // R4: pointer never runs past the list length
    a_r4_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ptr <= st_q.len);

    // R5: empty list returns the status byte
    a_r5_empty_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !any_rebuild && st_q.len == '0) |=> rd_data_o == $past(status));

    // R9: data holds without a read
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rd_data_o));

    // R8: read together with a rebuild leaves the pointer at 1 for a non-empty list
    a_r8_rebuild_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && any_rebuild && built_len != '0) |=> st_q.ptr == PTR_W'(1));
endmodule

// File: tb/dma_readback_seq_test.sv
module dma_readback_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  mask;
    logic        rebuild, stat_rebuild, rd;
    logic [15:0] bc, ca, cb;
    logic        en, pol, rdy_n, match, blk_end;
    logic [1:0]  mode;
    logic [7:0]  dout;

    int vectors = 0;
    int miscompares = 0;
    string tag = "R7";

    int q[$];
    int mptr = 0;
    logic [7:0] exp_data = 8'h38;

    always #4 clk = ~clk;

    dma_readback_seq uut (
        .clk_i(clk), .rst_ni(rst_n), .mask_i(mask), .rebuild_i(rebuild),
        .stat_rebuild_i(stat_rebuild), .rd_i(rd), .byte_cnt_i(bc),
        .cnt_a_i(ca), .cnt_b_i(cb), .enable_i(en), .mode_i(mode),
        .ready_pol_i(pol), .ready_n_i(rdy_n), .match_seen_i(match),
        .block_end_i(blk_end), .rd_data_o(dout)
    );

    function automatic logic [7:0] model_status();
        logic [7:0] s = 8'h00;
        if (en) s = s | 8'h01;
        if (mode != 2'd1 && rdy_n != pol) s = s | 8'h02;
        if (!match) s = s | 8'h10;
        if (!blk_end) s = s | 8'h20;
        return s;
    endfunction

    function automatic logic [7:0] model_byte(int code);
        case (code)
            0: return model_status();
            1: return bc[7:0];
            2: return bc[15:8];
            3: return ca[7:0];
            4: return ca[15:8];
            5: return cb[7:0];
            default: return cb[15:8];
        endcase
    endfunction

    task automatic compare();
        vectors++;
        if (dout !== exp_data) begin
            miscompares++;
            $display("FAIL %s: rd_data_o=%h expected %h at %0t", tag, dout, exp_data, $time);
        end
    endtask

    // apply current inputs for one clock, update model, compare at next negedge
    task automatic tick();
        logic [6:0] m;
        if (stat_rebuild || rebuild) begin
            m = stat_rebuild ? 7'h01 : mask;
            q.delete();
            for (int i = 0; i < 7; i++) if (m[i]) q.push_back(i);
            mptr = 0;
        end
        if (rd) begin
            if (q.size() == 0) exp_data = model_status();
            else begin
                if (mptr >= q.size()) mptr = 0;
                exp_data = model_byte(q[mptr]);
                mptr++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare();
        rebuild = 1'b0; stat_rebuild = 1'b0; rd = 1'b0;
    endtask

    task automatic do_read(int n);
        for (int i = 0; i < n; i++) begin rd = 1'b1; tick(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mask = 7'h00; rebuild = 0; stat_rebuild = 0; rd = 0;
        bc = 16'h1122; ca = 16'h3344; cb = 16'h5566;
        en = 0; mode = 2'd0; pol = 0; rdy_n = 1; match = 0; blk_end = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R7"; compare();            // reset data 0x38
        tick(); compare();

        tag = "R5";                       // empty list returns status
        en = 1; do_read(2);
        match = 1; do_read(1);

        tag = "R1 R4";                    // full order and wrap
        mask = 7'h7F; rebuild = 1; tick();
        do_read(9);
        bc = 16'hA1B2; ca = 16'hC3D4; cb = 16'hE5F6; do_read(8);

        tag = "R2";                       // sparse mask, then mask changes ignored
        mask = 7'h2A; rebuild = 1; tick();
        do_read(4);
        mask = 7'h7F; do_read(4);
        mask = 7'h00; tick(); do_read(2);

        tag = "R3";                       // status-only rebuild ignores mask
        mask = 7'h7E; stat_rebuild = 1; rebuild = 1; tick();
        do_read(2);

        tag = "R10 R6";                   // live status composition
        en = 0; do_read(1);
        match = 0; blk_end = 1; do_read(1);
        mode = 2'd1; rdy_n = 1; pol = 0; do_read(1);
        mode = 2'd2; do_read(1);
        rdy_n = 0; do_read(1);
        pol = 1; do_read(1);
        mode = 2'd3; en = 1; do_read(1);

        tag = "R8";                       // rebuild on a read cycle
        mask = 7'h18; rebuild = 1; rd = 1; tick();
        do_read(3);
        mask = 7'h00; rebuild = 1; rd = 1; tick();
        do_read(1);

        tag = "R9";                       // hold between reads
        mask = 7'h06; rebuild = 1; tick();
        do_read(1);
        bc = 16'h0F0E; repeat (3) tick();
        do_read(1);

        tag = "R1 R2 R4 R6";              // random phase
        for (int i = 0; i < 500; i++) begin
            mask = 7'($urandom);
            rebuild = ($urandom % 10) == 0;
            stat_rebuild = ($urandom % 25) == 0;
            rd = ($urandom % 3) != 0;
            bc = 16'($urandom); ca = 16'($urandom); cb = 16'($urandom);
            en = 1'($urandom); mode = 2'($urandom); pol = 1'($urandom);
            rdy_n = 1'($urandom); match = 1'($urandom); blk_end = 1'($urandom);
            tick();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule